// File: doc/BRIEF.md
# Six-Channel Pulse-Width Modulator with Enable-Triggered Reload

The block drives six independent pulse-width modulated outputs from a single clock. Software programs it through a plain word-addressed register port. Each channel has its own settings:

- a 3-bit clock divider;
- a 24-bit period length;
- a 24-bit active length.

A shared control word holds the per-channel run bits and polarity bits. A shared divider word packs all six divider fields.

Register writes only update staging copies. A channel copies its staged divider, period and active length into its running counters at one moment only: when its run bit changes from 0 to 1. Software therefore writes the new values, then clears and sets the run bit to apply them. The channel then restarts from the beginning of a period.

An active length of zero keeps the output at its inactive level, and this serves as the "off" setting. Polarity is not staged: a change to a polarity bit takes effect at once.

Top module: `pwm_bank`

## Requirements
- R1: After reset the control word (word 0) reads 0x3F3F3F00 and every other register reads 0. Every output rests low, because all channels are disabled and all polarity bits select normal polarity.
- R2: Word addresses are as follows. The control word is word 0 and the divider word is word 1. Channel n's period is word 2+2n and its active length is word 3+2n. `rd_data` returns the addressed register one cycle after `rd_en`. Period and active-length registers keep bits [23:0], and their upper bits read 0. Control and divider words read back all 32 bits as written. Unmapped words read 0.
- R3: The run bit of channel n is control bit n. Suppose the write that sets it is captured on clock edge E. Output sample k (k = 0, 1, ...) is the cycle after edge E+1+k. It is active when floor(k/(d+1)) mod P < A, where d is the divider, P the period and A the active length.
- R4: Channel n's divider is bits [4n+2:4n] of word 1. It stretches every count of the period to d+1 clock cycles.
- R5: Writes to the divider, period or active length of a running channel leave its output unchanged. The new values apply only after its run bit goes from 0 to 1.
- R6: A latched active length of 0 holds the output at its inactive level for the whole period.
- R7: A latched active length greater than or equal to the period holds the output active without a break.
- R8: Channel n's polarity is control bit 8+n. A value of 1 makes the active level high, and 0 makes it low. A change applies from the cycle after the write, without any reload.
- R9: One cycle after a channel's run bit is cleared, its output takes the inactive level. The next enable restarts the channel at sample k = 0.
- R10: A period value below 2 is latched as 2.
- R11: Channels run independently. Enabling, reloading or disabling one channel does not change the waveform of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, captured on the rising clock edge |
| rd_en | input | 1 | Read strobe; data is returned on the next cycle |
| addr | input | 4 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pwm_out | output | 6 | One modulated output per channel |

## Verification
A wrong prescale or period counter shows up within one period. The bench compares every output cycle against the phase formula, starting at the first cycle after reload, so a single extra or missing count is caught at that cycle. Staging errors are different: they show up only as a changed active-cycle count in a window of one full period. The bench therefore counts active cycles over whole periods while staged writes are pending. A run-edge detector that misfires shows up as a wrong phase, or as a missing reload on the first sample after re-enable.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  parameter int CNT_W = 24;
  parameter int PS_W  = 3;
  parameter int PS_STRIDE = 4;
  parameter int POL_BASE  = 8;

  typedef struct packed {
    logic [PS_W-1:0]  div;
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] act;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int N_CH   = 6,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter logic [DATA_W-1:0] CTRL_RST = 32'h3F3F3F00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [N_CH-1:0]   run_bits,
  output logic [N_CH-1:0]   pol_bits,
  output chan_cfg_t         cfg [N_CH]
);
  localparam int A_CTRL = 0;
  localparam int A_DIV  = 1;
  localparam int A_BASE = 2;

  logic [DATA_W-1:0] ctrl_q, div_q;
  logic [CNT_W-1:0]  per_q [N_CH];
  logic [CNT_W-1:0]  act_q [N_CH];
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      div_q  <= '0;
      for (int i = 0; i < N_CH; i++) begin
        per_q[i] <= '0;
        act_q[i] <= '0;
      end
    end else if (wr_en) begin
      if (int'(addr) == A_CTRL) ctrl_q <= wr_data;
      if (int'(addr) == A_DIV)  div_q  <= wr_data;
      for (int i = 0; i < N_CH; i++) begin
        if (int'(addr) == A_BASE + 2*i)     per_q[i] <= wr_data[CNT_W-1:0];
        if (int'(addr) == A_BASE + 2*i + 1) act_q[i] <= wr_data[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (int'(addr) == A_CTRL) rd_mux = ctrl_q;
    if (int'(addr) == A_DIV)  rd_mux = div_q;
    for (int i = 0; i < N_CH; i++) begin
      if (int'(addr) == A_BASE + 2*i)     rd_mux = DATA_W'(per_q[i]);
      if (int'(addr) == A_BASE + 2*i + 1) rd_mux = DATA_W'(act_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_fan
    assign run_bits[g] = ctrl_q[g];
    assign pol_bits[g] = ctrl_q[POL_BASE + g];
    assign cfg[g].div  = div_q[PS_STRIDE*g +: PS_W];
    assign cfg[g].per  = per_q[g];
    assign cfg[g].act  = act_q[g];
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == A_CTRL) |=> (ctrl_q == $past(wr_data))) else $error("ctrl write lost"); // R2
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)) else $error("rd_data moved without strobe"); // R2
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_i,
  input  logic      pol_i,
  input  chan_cfg_t cfg_i,
  output logic      pwm_o
);
  localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic             run_d, live;
  logic [PS_W-1:0]  div_l, pre_cnt;
  logic [CNT_W-1:0] per_l, act_l, cnt;
  logic             active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_d   <= 1'b0;
      live    <= 1'b0;
      div_l   <= '0;
      per_l   <= MIN_PER;
      act_l   <= '0;
      cnt     <= '0;
      pre_cnt <= '0;
    end else begin
      run_d <= run_i;
      if (!run_i) begin
        live    <= 1'b0;
        cnt     <= '0;
        pre_cnt <= '0;
      end else if (!run_d) begin
        live    <= 1'b1;
        div_l   <= cfg_i.div;
        per_l   <= (cfg_i.per < MIN_PER) ? MIN_PER : cfg_i.per;
        act_l   <= cfg_i.act;
        cnt     <= '0;
        pre_cnt <= '0;
      end else if (live) begin
        if (pre_cnt == div_l) begin
          pre_cnt <= '0;
          cnt     <= (cnt == per_l - ONE) ? '0 : cnt + ONE;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end

  assign active = live && (cnt < act_l);
  assign pwm_o  = pol_i ? active : !active;

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (cnt < per_l)) else $error("count beyond period"); // R3
  AST_PRE_IN_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (pre_cnt <= div_l)) else $error("divider overrun"); // R4
  AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (live && run_i) |=> ($stable(div_l) && $stable(per_l) && $stable(act_l))) else $error("reload without run edge"); // R5
  AST_ZERO_ACT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_l == '0) |-> (pwm_o == !pol_i)) else $error("zero length not idle"); // R6
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_i) |=> (pwm_o == !pol_i)) else $error("output not idle after stop"); // R9
  AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (per_l >= MIN_PER)) else $error("period below minimum"); // R10
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int N_CH   = 6,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [N_CH-1:0]   pwm_out
);
  localparam int N_WORDS = 2 + 2*N_CH;

  logic [N_CH-1:0] run_bits, pol_bits;
  chan_cfg_t       cfg [N_CH];

  pwm_bank_regs #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wr_data, .rd_data,
    .run_bits, .pol_bits, .cfg
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pwm_bank_chan u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (run_bits[g]),
      .pol_i (pol_bits[g]),
      .cfg_i (cfg[g]),
      .pwm_o (pwm_out[g])
    );
  end

  initial begin
    AST_ADDR_FITS: assert ((1 << ADDR_W) >= N_WORDS) else $error("address too narrow"); // R2
  end
endmodule

// File: tb/sim_pwm_bank.sv
`timescale 1ns/1ps
module sim_pwm_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [5:0]  pwm_out;

  always #2.5 clk = ~clk;

  pwm_bank u0 (.clk, .rst_n, .wr_en, .rd_en, .addr, .wr_data, .rd_data, .pwm_out);

  typedef struct { string req; logic [31:0] val; } exp_t;
  exp_t        exp_q[$];
  logic [31:0] act_q[$];
  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] ctrl_sh = 32'h3F3F3F00;

  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      exp_t e;
      logic [31:0] a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      checks++;
      if (a !== e.val) begin
        failures++;
        $display("FAIL %s actual=0x%08h expected=0x%08h", e.req, a, e.val);
      end
    end
  end

  task automatic check(string req, logic [31:0] expv, logic [31:0] actv);
    exp_q.push_back('{req, expv});
    act_q.push_back(actv);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = 4'(a);
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic set_ctrl(logic [31:0] v);
    ctrl_sh = v;
    wr(0, v);
  endtask

  task automatic restart(int ch);
    set_ctrl(ctrl_sh & ~(32'h1 << ch));
    set_ctrl(ctrl_sh | (32'h1 << ch));
  endtask

  // phase-exact comparison from sample k = 0 over two periods
  task automatic wave(string req, int ch, int dv, int per, int act, bit pol);
    int p, bad;
    p = (per < 2) ? 2 : per;
    bad = 0;
    for (int k = 0; k < 2*p*(dv+1); k++) begin
      bit a, e;
      @(negedge clk);
      a = ((k/(dv+1)) % p) < act;
      e = pol ? a : !a;
      if (pwm_out[ch] !== e) bad++;
    end
    check(req, 0, bad);
  endtask

  task automatic high_cnt(int ch, int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[ch] === 1'b1) c++;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(0, d);  check("R1 ctrl reset", 32'h3F3F3F00, d);
    check("R1 outputs idle", 0, 32'(pwm_out));
    rd(2, d);  check("R1 period reset", 0, d);

    wr(1, 32'h0010_0020);          // ch1 div 2, ch5 div 1
    wr(2, 32'hFF00_0005); wr(3, 2);
    wr(4, 4); wr(5, 1);
    wr(12, 3); wr(13, 1);
    rd(1, d);  check("R2 divider readback", 32'h0010_0020, d);
    rd(2, d);  check("R2 period upper bits", 32'h0000_0005, d);
    rd(3, d);  check("R2 active readback", 2, d);
    rd(14, d); check("R2 unmapped", 0, d);
    check("R9 staged only, outputs idle", 0, 32'(pwm_out));

    set_ctrl(ctrl_sh | 32'h1);
    wave("R3 ch0 div0 per5 act2", 0, 0, 5, 2, 1);
    set_ctrl(ctrl_sh | 32'h2);
    wave("R4 ch1 div2 per4 act1", 1, 2, 4, 1, 1);
    high_cnt(0, 5, c); check("R11 ch0 unaffected by ch1", 2, c);

    wr(3, 4); wr(2, 7); wr(1, 32'h0010_0027);
    high_cnt(0, 5, c); check("R5 staged writes ignored", 2, c);
    set_ctrl(ctrl_sh & ~32'h1);
    @(negedge clk); check("R9 stop idles output", 0, 32'(pwm_out[0]));
    wr(1, 32'h0010_0020); wr(2, 5);
    set_ctrl(ctrl_sh | 32'h1);
    wave("R5 reload applies new active", 0, 0, 5, 4, 1);

    set_ctrl(ctrl_sh | 32'h20);
    wave("R11 ch5 map div1 per3 act1", 5, 1, 3, 1, 1);

    wr(3, 0); restart(0);
    high_cnt(0, 10, c); check("R6 zero active idle", 0, c);
    wr(3, 5); restart(0);
    high_cnt(0, 10, c); check("R7 act equal period", 10, c);
    wr(3, 9); restart(0);
    high_cnt(0, 10, c); check("R7 act above period", 10, c);

    set_ctrl(ctrl_sh & ~32'h100);
    high_cnt(0, 5, c); check("R8 polarity live invert", 0, c);
    wr(3, 2); restart(0);
    wave("R8 inverted waveform", 0, 0, 5, 2, 0);
    set_ctrl(ctrl_sh & ~32'h1);
    @(negedge clk); check("R9 idle level inverted", 1, 32'(pwm_out[0]));
    set_ctrl(ctrl_sh | 32'h100);

    wr(2, 1); wr(3, 1);
    set_ctrl(ctrl_sh | 32'h1);
    wave("R10 period 1 clamps to 2", 0, 0, 1, 1, 1);
    wr(2, 0); restart(0);
    wave("R10 period 0 clamps to 2", 0, 0, 0, 1, 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule